// File: doc/BRIEF.md
# Indirect Register Port with Key-Event Scheduler

This block sits between a host processor and the control logic of an eight-voice sound engine. The host reaches a 128-byte register file through two ports that share one bus. It writes a register index to the address port, then reads or writes the selected byte through the data port. Reads always return the stored byte, never a live copy of engine state.

Two registers in the file hold per-voice key masks: a note-start mask at index 0x4C and a note-release mask at index 0x5C. Bit n of each belongs to voice n. The engine raises `sample_tick` once per sample period. The block samples both masks on every second tick only. For each voice it then emits a one-cycle start pulse and, one cycle later, a one-cycle release pulse. It also keeps a per-voice gate that shows attack (1) or release (0).

The byte at index 0x7C is the per-voice end-of-sample status. Voice logic sets bits in it, and a start pulse clears the bit of the voice being started.

Top module: `snd_regport`

## Requirements
- R1: A write with `bus_sel_addr`=1 loads the address register. A write with `bus_sel_addr`=0 stores `bus_wdata` at index addr[6:0]. `bus_rdata` always shows the byte stored at index addr[6:0].
- R2: After an address write with bit 7 set, data-port writes change nothing, until an address with bit 7 clear is written. Reads still return the byte at addr[6:0].
- R3: Reads return the stored byte. The key masks read back exactly as written, even after sampling, and are never cleared by the block.
- R4: After reset the masks are sampled only on the 2nd, 4th, 6th, ... `sample_tick` pulse. The odd ticks produce no pulses.
- R5: At a sampling edge, each voice whose bit is set in the 0x4C mask gets a `voice_start` pulse. The pulse is high for exactly the one cycle after that edge.
- R6: Each voice whose bit is set in the 0x5C mask at a sampling edge gets a `voice_release` pulse one cycle after the start pulses of the same sampling.
- R7: A start pulse sets the voice's gate to 1 (attack), and a release pulse sets it to 0. When both mask bits are set, the gate reads 1 and then ends at 0.
- R8: A high `voice_end_set[n]` sets bit n of the byte at 0x7C. A `voice_start[n]` pulse clears that bit, and the clear wins when both fall in the same cycle.
- R9: A mask bit that the host clears before the next sampling edge produces no pulse.
- R10: After reset every register byte, the address, all pulses and all gates are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_sel_addr | input | 1 | 1 selects the address port, 0 selects the data port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Byte stored at the current index |
| sample_tick | input | 1 | One-cycle pulse per sample period |
| voice_end_set | input | 8 | Per-voice end-of-sample set pulses |
| voice_start | output | 8 | Per-voice note-start pulses |
| voice_release | output | 8 | Per-voice release pulses |
| voice_gate | output | 8 | Per-voice envelope state, 1 = attack, 0 = release |

## Verification
Two updates can land on the end-of-sample status byte in the same cycle: a flag set from the voice logic and the clear caused by a start pulse. The bench provokes this by raising `voice_end_set` for the voice being started in exactly the cycle its start pulse is high. It then reads the status byte back and expects the bit to be clear while a neighbouring set bit survives. It also sets both mask bits for one voice and judges the ordering from the pulse cycles and the gate value after each pulse.

// File: rtl/snd_regport_pkg.sv
package snd_regport_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned IDX_W = 7;
  localparam int unsigned NV    = 8;
  localparam logic [IDX_W-1:0] IDX_KEY_ON  = 7'h4C;
  localparam logic [IDX_W-1:0] IDX_KEY_OFF = 7'h5C;
  localparam logic [IDX_W-1:0] IDX_END     = 7'h7C;
endpackage

// File: rtl/regport_host.sv
module regport_host #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_sel_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] addr_q,
  output logic              wr_en,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned LOCK_BIT = DATA_W - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (bus_wr && bus_sel_addr) addr_q <= bus_wdata;
  end

  assign idx   = addr_q[IDX_W-1:0];
  assign wr_en = bus_wr && !bus_sel_addr && !addr_q[LOCK_BIT];
endmodule

// File: rtl/regport_regfile.sv
module regport_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 7,
  parameter logic [IDX_W-1:0] KON_IDX  = 7'h4C,
  parameter logic [IDX_W-1:0] KOFF_IDX = 7'h5C,
  parameter logic [IDX_W-1:0] END_IDX  = 7'h7C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] end_set,
  input  logic [DATA_W-1:0] end_clr,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] kon_bits,
  output logic [DATA_W-1:0] koff_bits,
  output logic [DATA_W-1:0] end_bits
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] end_base;
  logic [DATA_W-1:0] end_next;

  always_comb begin
    end_base = (wr_en && idx == END_IDX) ? wdata : mem[END_IDX];
    end_next = (end_base | end_set) & ~end_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_en) mem[idx] <= wdata;
      mem[END_IDX] <= end_next;
    end
  end

  assign rdata     = mem[idx];
  assign kon_bits  = mem[KON_IDX];
  assign koff_bits = mem[KOFF_IDX];
  assign end_bits  = mem[END_IDX];
endmodule

// File: rtl/regport_keysched.sv
module regport_keysched #(
  parameter int unsigned NV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic [NV-1:0] kon_bits,
  input  logic [NV-1:0] koff_bits,
  output logic [NV-1:0] start_p,
  output logic [NV-1:0] release_p,
  output logic [NV-1:0] gate
);
  logic          phase;
  logic          take;
  logic [NV-1:0] off_hold;

  assign take = sample_tick && phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      start_p   <= '0;
      off_hold  <= '0;
      release_p <= '0;
    end else begin
      if (sample_tick) phase <= ~phase;
      start_p   <= take ? kon_bits  : '0;
      off_hold  <= take ? koff_bits : '0;
      release_p <= off_hold;
    end
  end

  for (genvar v = 0; v < NV; v++) begin : g_gate
    always_ff @(posedge clk) begin
      if (!rst_n)            gate[v] <= 1'b0;
      else if (release_p[v]) gate[v] <= 1'b0;
      else if (start_p[v])   gate[v] <= 1'b1;
    end
  end
endmodule

// File: rtl/snd_regport.sv
module snd_regport
  import snd_regport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_sel_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sample_tick,
  input  logic [NV-1:0] voice_end_set,
  output logic [NV-1:0] voice_start,
  output logic [NV-1:0] voice_release,
  output logic [NV-1:0] voice_gate
);
  logic [DW-1:0]    addr_reg;
  logic             wr_en;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    kon_bits, koff_bits, endx_flags;

  regport_host #(.DATA_W(DW), .IDX_W(IDX_W)) u_host (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_addr(bus_sel_addr),
    .bus_wdata(bus_wdata), .addr_q(addr_reg), .wr_en(wr_en), .idx(idx)
  );

  regport_regfile #(
    .DATA_W(DW), .IDX_W(IDX_W),
    .KON_IDX(IDX_KEY_ON), .KOFF_IDX(IDX_KEY_OFF), .END_IDX(IDX_END)
  ) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wdata(bus_wdata),
    .end_set(voice_end_set), .end_clr(voice_start), .rdata(bus_rdata),
    .kon_bits(kon_bits), .koff_bits(koff_bits), .end_bits(endx_flags)
  );

  regport_keysched #(.NV(NV)) u_keys (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .kon_bits(kon_bits), .koff_bits(koff_bits),
    .start_p(voice_start), .release_p(voice_release), .gate(voice_gate)
  );
endmodule

// File: rtl/snd_regport_chk.sv
module snd_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_sel_addr,
  input logic [7:0] bus_rdata,
  input logic       sample_tick,
  input logic [7:0] voice_start,
  input logic [7:0] voice_release,
  input logic [7:0] voice_gate,
  input logic [7:0] addr_q,
  input logic [7:0] endx_q
);
  a_r4_start_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|voice_start) |-> $past(sample_tick));

  a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|voice_start) |=> (voice_start == 8'h00));

  a_r6_release_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (|voice_release) |-> $past(sample_tick, 2));

  a_r7_release_drops_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (|voice_release) |=> ((voice_gate & $past(voice_release)) == 8'h00));

  a_r7_start_raises_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((|voice_start) && (voice_release == 8'h00)) |=>
      ((voice_gate & $past(voice_start)) == $past(voice_start)));

  a_r8_start_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
    (|voice_start) |=> ((endx_q & $past(voice_start)) == 8'h00));

  a_r2_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel_addr && addr_q[7] && addr_q[6:0] != 7'h7C) |=>
      (bus_rdata == $past(bus_rdata)));
endmodule

bind snd_regport snd_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_addr(bus_sel_addr),
  .bus_rdata(bus_rdata), .sample_tick(sample_tick), .voice_start(voice_start),
  .voice_release(voice_release), .voice_gate(voice_gate),
  .addr_q(addr_reg), .endx_q(endx_flags)
);

// File: tb/sim_snd_regport.sv
`timescale 1ns/1ps
module sim_snd_regport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_sel_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sample_tick = 1'b0;
  logic [7:0] voice_end_set = 8'h00;
  logic [7:0] voice_start, voice_release, voice_gate;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  snd_regport u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_sel_addr = sel; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    wr(1'b1, a); d = bus_rdata;
  endtask

  // one tick; returns start (cycle after edge), release (next), gate after both
  task automatic tick(output logic [7:0] st, output logic [7:0] rl,
                      output logic [7:0] gmid, output logic [7:0] gend);
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0; st = voice_start;
    @(negedge clk); rl = voice_release; gmid = voice_gate;
    @(negedge clk); gend = voice_gate;
  endtask

  task automatic t_reset();
    chk("R10 rdata", bus_rdata, 8'h00);
    chk("R10 start", voice_start, 8'h00);
    chk("R10 release", voice_release, 8'h00);
    chk("R10 gate", voice_gate, 8'h00);
  endtask

  task automatic t_rw();
    logic [7:0] d;
    wr(1'b1, 8'h0C); wr(1'b0, 8'h5A);
    wr(1'b1, 8'h1D); wr(1'b0, 8'hC3);
    rd(8'h0C, d); chk("R1 readback 0C", d, 8'h5A);
    rd(8'h1D, d); chk("R1 readback 1D", d, 8'hC3);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    wr(1'b1, 8'h8C); wr(1'b0, 8'h11);
    chk("R2 locked write ignored", bus_rdata, 8'h5A);
    wr(1'b1, 8'h0C); wr(1'b0, 8'h22);
    rd(8'h0C, d); chk("R2 unlocked write", d, 8'h22);
  endtask

  task automatic t_keyon();
    logic [7:0] st, rl, gm, ge, d;
    wr(1'b1, 8'h4C); wr(1'b0, 8'h05);
    tick(st, rl, gm, ge); chk("R4 odd tick no start", st, 8'h00);
    tick(st, rl, gm, ge);
    chk("R5 start on even tick", st, 8'h05);
    chk("R6 no release", rl, 8'h00);
    chk("R7 gate attack", ge, 8'h05);
    rd(8'h4C, d); chk("R3 mask kept", d, 8'h05);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_both();
    logic [7:0] st, rl, gm, ge;
    wr(1'b1, 8'h4C); wr(1'b0, 8'h81);
    wr(1'b1, 8'h5C); wr(1'b0, 8'h81);
    tick(st, rl, gm, ge);
    tick(st, rl, gm, ge);
    chk("R5 start both", st, 8'h81);
    chk("R6 release after start", rl, 8'h81);
    chk("R7 gate after start", gm, 8'h85);
    chk("R7 gate ends release", ge, 8'h04);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h4C); wr(1'b0, 8'h00);
  endtask

  task automatic t_lost();
    logic [7:0] st, rl, gm, ge;
    wr(1'b1, 8'h4C); wr(1'b0, 8'h10);
    tick(st, rl, gm, ge);
    wr(1'b0, 8'h00);
    tick(st, rl, gm, ge);
    chk("R9 cleared bit lost", st, 8'h00);
    chk("R9 gate unchanged", ge, 8'h04);
  endtask

  task automatic t_endx();
    logic [7:0] d;
    @(negedge clk); voice_end_set = 8'h30;
    @(negedge clk); voice_end_set = 8'h00;
    rd(8'h7C, d); chk("R8 end flags set", d, 8'h30);
    wr(1'b1, 8'h4C); wr(1'b0, 8'h10);
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;            // odd tick
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0; voice_end_set = 8'h10; // start high now
    chk("R5 start for end test", voice_start, 8'h10);
    @(negedge clk); voice_end_set = 8'h00;
    wr(1'b0, 8'h00);
    rd(8'h7C, d); chk("R8 clear wins", d, 8'h20);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset(); t_rw(); t_protect(); t_keyon(); t_both(); t_lost(); t_endx();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule